// File: doc/BRIEF.md
# Per-thread fetch status tracker

This block keeps the fetch status of every hardware thread in a multithreaded front end. Each cycle it takes stall and release pulses from the four stages below fetch, squash requests from the commit and decode stages, a commit-side "still squashing" level, a global context-switch hold, and events from the instruction-cache controller. From these it computes each thread's next status.

Each thread has four sticky stall bits, one per downstream stage. The status of each thread follows a fixed priority chain. A squash from commit beats everything else. Threads that are waiting on the instruction cache are never forced into the blocked state.

The block also reports, per thread, whether a rule fired this cycle. It keeps a stage-level "fetch is busy" flag and raises one-cycle pulses when that flag turns on or off. The surrounding fetch logic uses the status to decide what to do next, and uses the busy flag to gate the stage's clocking or activity accounting.

Top module: `fetch_status_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every thread's status becomes running (code 1), all stall bits clear, and `status_chg_o`, `stage_busy_o`, `stage_on_o` and `stage_off_o` are 0.
- R2: Stall bits are sticky. For thread t and stage s, bit 4t+s of `stall_set_i` sets the bit and the same bit of `stall_clr_i` clears it. The stage indices are 0 decode, 1 rename, 2 execute, 3 commit. The thread stays blocked (code 3) while any of its bits is set. A clear pulse is only legal while the bit is set and never together with a set pulse.
- R3: A commit squash makes the thread squashing (code 2) with its change flag set, whatever else arrives in that cycle.
- R4: With no commit squash, an asserted still-squashing level keeps or makes the thread squashing with its change flag set, even when a stall bit is set.
- R5: A decode squash makes the thread squashing only if it is not already squashing. If it is already squashing, the lower-priority rules decide.
- R6: If no higher rule fires and a stall bit or `ctx_switch_i` is set, the thread becomes blocked. A thread waiting for a cache response (code 6) or a retry (code 5) keeps its status instead, with no change flagged.
- R7: If no higher rule fires, a blocked or squashing thread returns to running with its change flag set.
- R8: Cache events apply to the status left by the rules above:
  - A running thread with `miss_issue_i` waits for a response (6). With `miss_stall_i` it waits for a retry (5).
  - A retry-waiting thread with `retry_ok_i` waits for a response.
  - A response-waiting thread with `fill_done_i` becomes access-complete (code 4), or blocked if a stall is present.
  - `fill_done_i` in any other status is ignored.
- R9: An access-complete thread becomes running when `fetch_sel_i` selects it, and otherwise holds.
- R10: `stage_busy_o` is 1 exactly when some thread flagged in `thread_active_i` will be running, squashing or access-complete. `stage_on_o` and `stage_off_o` pulse for one cycle only when that flag rises or falls.
- R11: A thread's bit of `status_chg_o` is 0 in any cycle in which none of the rules or events above fires for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_active_i | input | NUM_THREADS | Threads that count toward stage activity |
| stall_set_i | input | NUM_THREADS*4 | Stall pulses, bit 4t+s for thread t, stage s |
| stall_clr_i | input | NUM_THREADS*4 | Release pulses, same layout |
| ctx_switch_i | input | 1 | Global hold that blocks all threads |
| cmt_squash_i | input | NUM_THREADS | Squash request from commit |
| cmt_busy_i | input | NUM_THREADS | Commit still squashing |
| dec_squash_i | input | NUM_THREADS | Squash request from decode |
| miss_issue_i | input | NUM_THREADS | Cache request accepted |
| miss_stall_i | input | NUM_THREADS | Cache request refused, retry needed |
| retry_ok_i | input | NUM_THREADS | Refused request now accepted |
| fill_done_i | input | NUM_THREADS | Cache response arrived |
| fetch_sel_i | input | NUM_THREADS | Thread selected for fetch this cycle |
| status_o | output | NUM_THREADS*4 | Status of thread t at bits 4t+3..4t |
| status_chg_o | output | NUM_THREADS | A rule or event fired for the thread |
| stage_busy_o | output | 1 | Fetch stage busy |
| stage_on_o | output | 1 | Busy flag rose |
| stage_off_o | output | 1 | Busy flag fell |

## Verification
The bench builds the tracker with NUM_THREADS set to 2. Two threads are enough to check that one thread's stall or squash leaves the other untouched. They also let the stage busy flag be held up by one thread while the other sits in a cache-wait state. With both threads blocked, or both marked inactive, the deactivation pulse can also be seen.

// File: rtl/fst_pkg.sv
// Shared types for the fetch status tracker.
// Assumes: status values fit four bits; stage index order decode, rename, execute, commit.
package fst_pkg;
    localparam int STW     = 4;
    localparam int NSTAGES = 4;

    typedef enum logic [STW-1:0] {
        ST_IDLE       = 4'd0,
        ST_RUNNING    = 4'd1,
        ST_SQUASHING  = 4'd2,
        ST_BLOCKED    = 4'd3,
        ST_ACC_DONE   = 4'd4,
        ST_WAIT_RETRY = 4'd5,
        ST_WAIT_RESP  = 4'd6,
        ST_TRAP_PEND  = 4'd7,
        ST_QUIESCE    = 4'd8
    } fst_status_e;
endpackage

// File: rtl/fst_stall_bits.sv
// Sticky per-stage stall bits for one thread.
// Assumes: a clear pulse arrives only while its bit is set and never with a set pulse.
module fst_stall_bits
    import fst_pkg::*;
#(
    parameter int N = NSTAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic         any_nx_o
);
    logic [N-1:0] bits_q;
    logic [N-1:0] bits_nx;

    // Next value: set pulses raise bits, release pulses drop them.
    always_comb begin
        bits_nx  = (bits_q | set_i) & ~clr_i;
        any_nx_o = |bits_nx;
    end

    // Hold the stall bits.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_nx;
    end

    // R2: release only while set, never with a set pulse
    p_clr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~bits_q) == '0) && ((clr_i & set_i) == '0));
    // R2: a set pulse leaves the bit set
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fst_thread_fsm.sv
// Status machine for one thread: priority chain of control inputs, then cache events.
// Assumes: the stall input already includes this cycle's stall-bit updates and the context hold.
module fst_thread_fsm
    import fst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmt_squash_i,
    input  logic        cmt_busy_i,
    input  logic        dec_squash_i,
    input  logic        stall_i,
    input  logic        miss_issue_i,
    input  logic        miss_stall_i,
    input  logic        retry_ok_i,
    input  logic        fill_done_i,
    input  logic        fetch_sel_i,
    output fst_status_e status_o,
    output fst_status_e status_nx_o,
    output logic        chg_o
);
    fst_status_e st_q;
    fst_status_e st_mid;
    fst_status_e st_nx;
    logic        rule_hit;
    logic        ev_hit;
    logic        chg_q;

    // Priority chain over the control inputs.
    always_comb begin
        st_mid   = st_q;
        rule_hit = 1'b0;
        if (cmt_squash_i) begin
            st_mid = ST_SQUASHING; rule_hit = 1'b1;
        end else if (cmt_busy_i) begin
            st_mid = ST_SQUASHING; rule_hit = 1'b1;
        end else if (dec_squash_i && st_q != ST_SQUASHING) begin
            st_mid = ST_SQUASHING; rule_hit = 1'b1;
        end else if (stall_i && st_q != ST_WAIT_RESP && st_q != ST_WAIT_RETRY) begin
            st_mid = ST_BLOCKED; rule_hit = 1'b1;
        end else if (st_q == ST_BLOCKED || st_q == ST_SQUASHING) begin
            st_mid = ST_RUNNING; rule_hit = 1'b1;
        end
    end

    // Cache and fetch-select events applied to the chain result.
    always_comb begin
        st_nx  = st_mid;
        ev_hit = 1'b0;
        case (st_mid)
            ST_RUNNING: begin
                if (miss_issue_i) begin
                    st_nx = ST_WAIT_RESP; ev_hit = 1'b1;
                end else if (miss_stall_i) begin
                    st_nx = ST_WAIT_RETRY; ev_hit = 1'b1;
                end
            end
            ST_WAIT_RETRY: if (retry_ok_i) begin
                st_nx = ST_WAIT_RESP; ev_hit = 1'b1;
            end
            ST_WAIT_RESP: if (fill_done_i) begin
                st_nx  = stall_i ? ST_BLOCKED : ST_ACC_DONE;
                ev_hit = 1'b1;
            end
            ST_ACC_DONE: if (fetch_sel_i) begin
                st_nx = ST_RUNNING; ev_hit = 1'b1;
            end
            default: st_nx = st_mid;
        endcase
    end

    // Status and change-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUNNING;
            chg_q <= 1'b0;
        end else begin
            st_q  <= st_nx;
            chg_q <= rule_hit | ev_hit;
        end
    end

    assign status_o    = st_q;
    assign status_nx_o = st_nx;
    assign chg_o       = chg_q;

    // R3: commit squash always lands in squashing with a change
    p_cmt_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash_i |=> (st_q == ST_SQUASHING) && chg_q);
    // R6: a response wait survives stalls when nothing else acts on it
    p_wait_exempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_RESP && !cmt_squash_i && !cmt_busy_i && !dec_squash_i
         && !fill_done_i) |=> (st_q == ST_WAIT_RESP) && !chg_q);
    // R9: selected access-complete thread resumes running
    p_acc_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACC_DONE && fetch_sel_i && !cmt_squash_i && !cmt_busy_i
         && !dec_squash_i && !stall_i) |=> (st_q == ST_RUNNING));
    // R4: still-squashing keeps squashing
    p_cmt_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_busy_i |=> (st_q == ST_SQUASHING));
endmodule

// File: rtl/fst_stage_activity.sv
// Stage busy flag with one-cycle rise and fall pulses.
// Assumes: status_nx_i holds each thread's next status, four bits per thread.
module fst_stage_activity
    import fst_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT*STW-1:0] status_nx_i,
    input  logic [NT-1:0]   thread_active_i,
    output logic            busy_o,
    output logic            on_o,
    output logic            off_o
);
    logic [NT-1:0] thr_busy;
    logic          busy_nx;
    logic          busy_q, on_q, off_q;

    // Per-thread busy decode.
    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [STW-1:0] s;
        assign s = status_nx_i[t*STW +: STW];
        assign thr_busy[t] = thread_active_i[t] &&
            (s == ST_RUNNING || s == ST_SQUASHING || s == ST_ACC_DONE);
    end

    assign busy_nx = |thr_busy;

    // Busy register and transition pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            on_q   <= 1'b0;
            off_q  <= 1'b0;
        end else begin
            busy_q <= busy_nx;
            on_q   <= busy_nx & ~busy_q;
            off_q  <= ~busy_nx & busy_q;
        end
    end

    assign busy_o = busy_q;
    assign on_o   = on_q;
    assign off_o  = off_q;

    // R10: pulses never together
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_q && off_q));
    // R10: an on pulse implies the flag is now set
    p_on_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        on_q |-> busy_q);
    // R10: an off pulse implies the flag is now clear
    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |-> !busy_q);
endmodule

// File: rtl/fetch_status_tracker.sv
// Top: per-thread stall bits and status machines plus stage activity.
// Assumes: all inputs are single-cycle pulses except thread_active_i, ctx_switch_i, cmt_busy_i.
module fetch_status_tracker
    import fst_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_THREADS-1:0]     thread_active_i,
    input  logic [NUM_THREADS*4-1:0]   stall_set_i,
    input  logic [NUM_THREADS*4-1:0]   stall_clr_i,
    input  logic                       ctx_switch_i,
    input  logic [NUM_THREADS-1:0]     cmt_squash_i,
    input  logic [NUM_THREADS-1:0]     cmt_busy_i,
    input  logic [NUM_THREADS-1:0]     dec_squash_i,
    input  logic [NUM_THREADS-1:0]     miss_issue_i,
    input  logic [NUM_THREADS-1:0]     miss_stall_i,
    input  logic [NUM_THREADS-1:0]     retry_ok_i,
    input  logic [NUM_THREADS-1:0]     fill_done_i,
    input  logic [NUM_THREADS-1:0]     fetch_sel_i,
    output logic [NUM_THREADS*4-1:0]   status_o,
    output logic [NUM_THREADS-1:0]     status_chg_o,
    output logic                       stage_busy_o,
    output logic                       stage_on_o,
    output logic                       stage_off_o
);
    localparam int SW = STW;

    logic [NUM_THREADS*SW-1:0] st_nx_flat;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic        stall_any;
        fst_status_e st_cur, st_nx;

        fst_stall_bits #(.N(NSTAGES)) u_stall (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (stall_set_i[t*NSTAGES +: NSTAGES]),
            .clr_i    (stall_clr_i[t*NSTAGES +: NSTAGES]),
            .any_nx_o (stall_any)
        );

        fst_thread_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .cmt_squash_i (cmt_squash_i[t]),
            .cmt_busy_i   (cmt_busy_i[t]),
            .dec_squash_i (dec_squash_i[t]),
            .stall_i      (stall_any | ctx_switch_i),
            .miss_issue_i (miss_issue_i[t]),
            .miss_stall_i (miss_stall_i[t]),
            .retry_ok_i   (retry_ok_i[t]),
            .fill_done_i  (fill_done_i[t]),
            .fetch_sel_i  (fetch_sel_i[t]),
            .status_o     (st_cur),
            .status_nx_o  (st_nx),
            .chg_o        (status_chg_o[t])
        );

        assign status_o[t*SW +: SW]   = st_cur;
        assign st_nx_flat[t*SW +: SW] = st_nx;
    end

    fst_stage_activity #(.NT(NUM_THREADS)) u_act (
        .clk             (clk),
        .rst_n           (rst_n),
        .status_nx_i     (st_nx_flat),
        .thread_active_i (thread_active_i),
        .busy_o          (stage_busy_o),
        .on_o            (stage_on_o),
        .off_o           (stage_off_o)
    );
endmodule

// File: tb/fetch_status_tracker_test.sv
module fetch_status_tracker_test;
    localparam int NT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0]   t_act;
    logic [NT*4-1:0] s_set, s_clr;
    logic            ctx;
    logic [NT-1:0]   c_sq, c_busy, d_sq, m_iss, m_stl, r_ok, f_done, f_sel;
    logic [NT*4-1:0] st;
    logic [NT-1:0]   chg;
    logic            busy, on, off;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] st;
        logic [1:0] chg;
        logic       busy, on, off;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    fetch_status_tracker #(.NUM_THREADS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .thread_active_i(t_act),
        .stall_set_i(s_set), .stall_clr_i(s_clr), .ctx_switch_i(ctx),
        .cmt_squash_i(c_sq), .cmt_busy_i(c_busy), .dec_squash_i(d_sq),
        .miss_issue_i(m_iss), .miss_stall_i(m_stl), .retry_ok_i(r_ok),
        .fill_done_i(f_done), .fetch_sel_i(f_sel),
        .status_o(st), .status_chg_o(chg),
        .stage_busy_o(busy), .stage_on_o(on), .stage_off_o(off)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] a, input logic [7:0] e);
        n_checks++;
        if (a !== e) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, a, e);
        end
    endtask

    // Monitor: pops one expectation per cycle and compares.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "status", st, e.st);
                chk(e.tag, "chg", {6'd0, chg}, {6'd0, e.chg});
                chk(e.tag, "busy", {7'd0, busy}, {7'd0, e.busy});
                chk(e.tag, "on", {7'd0, on}, {7'd0, e.on});
                chk(e.tag, "off", {7'd0, off}, {7'd0, e.off});
            end
        end
    end

    task automatic clear_pulses();
        s_set = '0; s_clr = '0; ctx = 1'b0;
        c_sq = '0; c_busy = '0; d_sq = '0;
        m_iss = '0; m_stl = '0; r_ok = '0; f_done = '0; f_sel = '0;
    endtask

    // Driver: push expectation (status t1,t0), advance one cycle, clear pulses.
    task automatic step(input logic [3:0] s1, input logic [3:0] s0, input logic [1:0] c,
                        input logic b, input logic o, input logic f, input string tag);
        exp_t e;
        e.st = {s1, s0}; e.chg = c; e.busy = b; e.on = o; e.off = f; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        clear_pulses();
    endtask

    initial begin
        clear_pulses();
        t_act = 2'b11;
        @(negedge clk);
        // R1 reset state
        step(1, 1, 2'b00, 0, 0, 0, "R1");
        step(1, 1, 2'b00, 0, 0, 0, "R1");
        rst_n = 1'b1;
        step(1, 1, 2'b00, 1, 1, 0, "R10 rise after reset");
        step(1, 1, 2'b00, 1, 0, 0, "R11 quiet");
        s_set[0] = 1'b1;                       // decode stall thread 0
        step(1, 3, 2'b01, 1, 0, 0, "R2 block");
        step(1, 3, 2'b01, 1, 0, 0, "R2 sticky");
        s_set[1] = 1'b1;                       // rename stall thread 0
        step(1, 3, 2'b01, 1, 0, 0, "R2 second stage");
        s_clr[0] = 1'b1;
        step(1, 3, 2'b01, 1, 0, 0, "R2 one still set");
        s_clr[1] = 1'b1;
        step(1, 1, 2'b01, 1, 0, 0, "R7 unblocked");
        step(1, 1, 2'b00, 1, 0, 0, "R11 running");
        ctx = 1'b1;
        step(3, 3, 2'b11, 0, 0, 1, "R6 ctx switch / R10 fall");
        step(1, 1, 2'b11, 1, 1, 0, "R7 R10 resume");
        c_sq[0] = 1'b1; d_sq[0] = 1'b1; s_set[2] = 1'b1;
        step(1, 2, 2'b01, 1, 0, 0, "R3 commit squash wins");
        step(1, 3, 2'b01, 1, 0, 0, "R6 stall after squash");
        s_clr[2] = 1'b1;
        step(1, 1, 2'b01, 1, 0, 0, "R7 release");
        c_busy[0] = 1'b1; s_set[3] = 1'b1;
        step(1, 2, 2'b01, 1, 0, 0, "R4 still squashing beats stall");
        c_busy[0] = 1'b1; s_clr[3] = 1'b1;
        step(1, 2, 2'b01, 1, 0, 0, "R4 hold");
        d_sq[0] = 1'b1;
        step(1, 1, 2'b01, 1, 0, 0, "R5 decode squash while squashing");
        d_sq[1] = 1'b1;
        step(2, 1, 2'b10, 1, 0, 0, "R5 decode squash");
        step(1, 1, 2'b10, 1, 0, 0, "R7 squash done");
        m_iss[0] = 1'b1;
        step(1, 6, 2'b01, 1, 0, 0, "R8 miss issued");
        ctx = 1'b1;
        step(3, 6, 2'b10, 0, 0, 1, "R6 wait exempt");
        f_done[1] = 1'b1;
        step(1, 6, 2'b10, 1, 1, 0, "R8 stray fill ignored");
        s_set[0] = 1'b1; f_done[0] = 1'b1;
        step(1, 3, 2'b01, 1, 0, 0, "R8 fill under stall");
        s_clr[0] = 1'b1;
        step(1, 1, 2'b01, 1, 0, 0, "R7 after fill");
        m_stl[0] = 1'b1;
        step(1, 5, 2'b01, 1, 0, 0, "R8 refused");
        s_set[0] = 1'b1;
        step(1, 5, 2'b00, 1, 0, 0, "R6 retry exempt");
        r_ok[0] = 1'b1;
        step(1, 6, 2'b01, 1, 0, 0, "R8 retry accepted");
        s_clr[0] = 1'b1; f_done[0] = 1'b1;
        step(1, 4, 2'b01, 1, 0, 0, "R8 fill complete");
        step(1, 4, 2'b00, 1, 0, 0, "R9 hold unselected");
        f_sel[0] = 1'b1;
        step(1, 1, 2'b01, 1, 0, 0, "R9 selected");
        t_act = 2'b00;
        step(1, 1, 2'b00, 0, 0, 1, "R10 inactive threads");
        step(1, 1, 2'b00, 0, 0, 0, "R10 single pulse");
        t_act = 2'b11;
        step(1, 1, 2'b00, 1, 1, 0, "R10 reactivate");
        m_iss[0] = 1'b1;
        step(1, 6, 2'b01, 1, 0, 0, "R8 issue");
        c_sq[0] = 1'b1;
        step(1, 2, 2'b01, 1, 0, 0, "R3 squash drops wait");
        f_done[0] = 1'b1;
        step(1, 1, 2'b01, 1, 0, 0, "R8 stale fill ignored");
        step(1, 1, 2'b00, 1, 0, 0, "R11 final");
        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule